// File: doc/BRIEF.md
# Two-Phase Bit Cycle Gate

This block turns a four-phase clock-track timing into the single pulse stream that drives the bit-timing delay chain. In drum mode it merges phase one and phase three. Each clock-track cycle therefore produces two bit cycles, which doubles the data-handling rate compared with the normal mode. When drum mode is low, one chosen phase is passed through instead. This stands in for the normal phase-selection path, which is not modelled here.

A small window state machine decides when pulses may leave the block. It has four states:
- `WIN_IDLE`: the gate is closed.
- `WIN_INDEX`: the gate is held open for index-area filler timing during writes.
- `WIN_RUN`: the gate is open inside an address or record area.
- `WIN_CHECK`: the gate is open inside the check area.

The transitions are:
- `IDLE→RUN` on an area start.
- `IDLE→INDEX` on the hold-on-index request.
- `INDEX→RUN` on an area start.
- `RUN→IDLE` on the D2 bit-sync strobe, in normal read only.
- `RUN→CHECK` when check area is asserted.
- `CHECK→IDLE` on the D5 strobe in drum mode, or on the late end strobe in normal mode.
- Any state returns to `IDLE` on the idle reset.

Every phase input is edge-detected. The output pulse is registered, one system clock wide, and appears in the cycle after the rising phase level is first sampled.

Top module: `bit_cycle_gate`

## Requirements
- R1: After rst_n is released, bit_cycle_o, gate_open_o and check_window_o are all 0.
- R2: In drum mode with the gate open, a rising level on phase_in[0] (phase one) or on phase_in[2] (phase three) gives a one-cycle high on bit_cycle_o one clock after the level is first sampled high.
- R3: In drum mode, rising levels on phase_in[1] (phase two) and phase_in[3] (phase four) never produce a pulse.
- R4: In normal mode (drum_mode=0), only the phase whose index equals normal_sel (0 = phase one … 3 = phase four) produces pulses.
- R5: A phase input held high for several cycles produces only one pulse.
- R6: While the gate is closed (gate_open_o=0), phase edges produce no pulse.
- R7: area_start moves the window from IDLE or INDEX to RUN, so gate_open_o=1 on the next cycle.
- R8: hold_on_index moves the window from IDLE to INDEX, so gate_open_o=1 on the next cycle.
- R9: d2_bs_strobe in RUN closes the gate only in normal read mode. In drum mode it is ignored and pulses keep flowing.
- R10: check_area in RUN enters CHECK (check_window_o=1). In CHECK, drum mode closes the gate on d5_strobe and ignores late_end_strobe. Normal mode closes it on late_end_strobe and ignores d5_strobe.
- R11: idle_rst synchronously closes the gate from any state and suppresses the pulse of that cycle. It takes priority over every other input.
- R12: In drum mode with the gate open, one full four-phase track cycle yields exactly two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_rst | input | 1 | Synchronous machine-idle clear |
| drum_mode | input | 1 | 1 selects the two-phase drum path |
| phase_in | input | 4 | Clock-track phase levels, bit 0 = phase one |
| normal_sel | input | 2 | Phase index passed through in normal mode |
| area_start | input | 1 | Address or record area begins |
| hold_on_index | input | 1 | Open the gate for index filler timing |
| read_mode | input | 1 | 1 during read operations |
| d2_bs_strobe | input | 1 | Bit-sync time of digit D2 |
| check_area | input | 1 | Check area is active |
| d5_strobe | input | 1 | Digit D5 timing (drum check end) |
| late_end_strobe | input | 1 | Later check-end digit (normal mode) |
| bit_cycle_o | output | 1 | Begin-bit-cycle pulse |
| gate_open_o | output | 1 | Window state is not IDLE |
| check_window_o | output | 1 | Window state is CHECK |

## Verification
Several properties are checked by the assertions on every cycle:
- No pulse leaves a closed gate.
- Drum mode never emits a pulse that was not caused by phase one or phase three.
- A detected edge never lasts two cycles.
- The idle reset always closes the window.
- Drum mode never leaves RUN through the D2 stop.
- Normal mode never leaves CHECK on anything but the late strobe.

Other behaviours can only be shown by the bench's scenarios:
- The exact pulse count per track cycle.
- The mode-dependent pass-through of the chosen phase in normal mode.
- The order of window transitions across area start, index hold, D2 and check end.
- The latency of each pulse relative to its phase edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_INDEX = 2'd1,
        WIN_RUN   = 2'd2,
        WIN_CHECK = 2'd3
    } win_state_e;

endpackage

// File: rtl/bcg_edge_det.sv
module bcg_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise_o[i] = level_i[i] & ~prev_q[i];

        // R5: a detected rise never lasts two cycles
        a_r5_single_rise : assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
    end

endmodule

// File: rtl/bcg_phase_merge.sv
module bcg_phase_merge #(
    parameter int N       = 4,
    parameter int PHASE_A = 0,
    parameter int PHASE_B = 2,
    localparam int SEL_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     rise_i,
    input  logic             drum_mode_i,
    input  logic [SEL_W-1:0] normal_sel_i,
    output logic             sel_rise_o
);

    logic [N-1:0] drum_mask;
    logic         drum_hit;
    logic         normal_hit;

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign drum_mask[i] = (i == PHASE_A) || (i == PHASE_B);
    end

    assign drum_hit = |(rise_i & drum_mask);

    always_comb begin
        normal_hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (normal_sel_i == SEL_W'(k)) normal_hit = rise_i[k];
        end
    end

    assign sel_rise_o = drum_mode_i ? drum_hit : normal_hit;

endmodule

// File: rtl/bcg_window_fsm.sv
module bcg_window_fsm
    import bcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_rst_i,
    input  logic drum_mode_i,
    input  logic area_start_i,
    input  logic hold_on_index_i,
    input  logic read_mode_i,
    input  logic d2_bs_i,
    input  logic check_area_i,
    input  logic d5_i,
    input  logic late_end_i,
    output logic gate_open_o,
    output logic in_check_o
);

    win_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (idle_rst_i) begin
            state_d = WIN_IDLE;
        end else begin
            unique case (state_q)
                WIN_IDLE: begin
                    if (area_start_i)         state_d = WIN_RUN;
                    else if (hold_on_index_i) state_d = WIN_INDEX;
                end
                WIN_INDEX: begin
                    if (area_start_i) state_d = WIN_RUN;
                end
                WIN_RUN: begin
                    if (!drum_mode_i && read_mode_i && d2_bs_i) state_d = WIN_IDLE;
                    else if (check_area_i)                      state_d = WIN_CHECK;
                end
                WIN_CHECK: begin
                    if (drum_mode_i ? d5_i : late_end_i) state_d = WIN_IDLE;
                end
                default: state_d = WIN_IDLE;
            endcase
        end
    end

    always_comb begin
        gate_open_o = (state_q != WIN_IDLE);
        in_check_o  = (state_q == WIN_CHECK);
    end

    // R9: drum mode never leaves RUN through the D2 stop
    a_r9_drum_keeps_running : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_RUN && drum_mode_i && !idle_rst_i) |=> (state_q != WIN_IDLE));

    // R10: normal mode stays in CHECK until the late strobe
    a_r10_normal_check_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_CHECK && !drum_mode_i && !late_end_i && !idle_rst_i)
        |=> (state_q == WIN_CHECK));

    // R11: idle reset always closes the window
    a_r11_idle_closes : assert property (@(posedge clk) disable iff (!rst_n)
        idle_rst_i |=> (state_q == WIN_IDLE));

endmodule

// File: rtl/bit_cycle_gate.sv
module bit_cycle_gate #(
    parameter int NUM_PHASES = 4,
    parameter int DRUM_PH_A  = 0,
    parameter int DRUM_PH_B  = 2,
    localparam int SEL_W     = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idle_rst,
    input  logic                  drum_mode,
    input  logic [NUM_PHASES-1:0] phase_in,
    input  logic [SEL_W-1:0]      normal_sel,
    input  logic                  area_start,
    input  logic                  hold_on_index,
    input  logic                  read_mode,
    input  logic                  d2_bs_strobe,
    input  logic                  check_area,
    input  logic                  d5_strobe,
    input  logic                  late_end_strobe,
    output logic                  bit_cycle_o,
    output logic                  gate_open_o,
    output logic                  check_window_o
);

    logic [NUM_PHASES-1:0] rise;
    logic                  sel_rise;
    logic                  gate_open;
    logic                  in_check;
    logic                  pulse_q;

    bcg_edge_det #(.N(NUM_PHASES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (phase_in),
        .rise_o  (rise)
    );

    bcg_phase_merge #(
        .N       (NUM_PHASES),
        .PHASE_A (DRUM_PH_A),
        .PHASE_B (DRUM_PH_B)
    ) u_merge (
        .rise_i       (rise),
        .drum_mode_i  (drum_mode),
        .normal_sel_i (normal_sel),
        .sel_rise_o   (sel_rise)
    );

    bcg_window_fsm u_win (
        .clk             (clk),
        .rst_n           (rst_n),
        .idle_rst_i      (idle_rst),
        .drum_mode_i     (drum_mode),
        .area_start_i    (area_start),
        .hold_on_index_i (hold_on_index),
        .read_mode_i     (read_mode),
        .d2_bs_i         (d2_bs_strobe),
        .check_area_i    (check_area),
        .d5_i            (d5_strobe),
        .late_end_i      (late_end_strobe),
        .gate_open_o     (gate_open),
        .in_check_o      (in_check)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pulse_q <= 1'b0;
        else if (idle_rst) pulse_q <= 1'b0;
        else               pulse_q <= gate_open & sel_rise;
    end

    assign bit_cycle_o    = pulse_q;
    assign gate_open_o    = gate_open;
    assign check_window_o = in_check;

    // R6: a pulse only follows a cycle with the gate open
    a_r6_closed_no_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        bit_cycle_o |-> $past(gate_open));

    // R3: in drum mode only phase one or three can cause a pulse
    a_r3_drum_phase_only : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drum_mode) && !$past(phase_in[DRUM_PH_A]) && !$past(phase_in[DRUM_PH_B]))
        |-> !bit_cycle_o);

    // R11: idle reset suppresses the pulse of its cycle
    a_r11_idle_no_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        $past(idle_rst) |-> (!bit_cycle_o && !gate_open_o));

endmodule

// File: tb/test_bit_cycle_gate.sv
`timescale 1ns/1ps
module test_bit_cycle_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_rst = 1'b0;
    logic       drum_mode = 1'b0;
    logic [3:0] phase_in = 4'b0;
    logic [1:0] normal_sel = 2'd0;
    logic       area_start = 1'b0;
    logic       hold_on_index = 1'b0;
    logic       read_mode = 1'b0;
    logic       d2_bs_strobe = 1'b0;
    logic       check_area = 1'b0;
    logic       d5_strobe = 1'b0;
    logic       late_end_strobe = 1'b0;
    logic       bit_cycle_o, gate_open_o, check_window_o;

    always #2 clk = ~clk;

    bit_cycle_gate i_bit_cycle_gate (
        .clk(clk), .rst_n(rst_n), .idle_rst(idle_rst), .drum_mode(drum_mode),
        .phase_in(phase_in), .normal_sel(normal_sel), .area_start(area_start),
        .hold_on_index(hold_on_index), .read_mode(read_mode),
        .d2_bs_strobe(d2_bs_strobe), .check_area(check_area),
        .d5_strobe(d5_strobe), .late_end_strobe(late_end_strobe),
        .bit_cycle_o(bit_cycle_o), .gate_open_o(gate_open_o),
        .check_window_o(check_window_o)
    );

    typedef struct {
        int    stamp;
        logic  p;
        logic  g;
        logic  c;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    int   seen_pulses = 0;
    int   m_st = 0;          // 0 idle, 1 index, 2 run, 3 check
    logic [3:0] m_prev = 4'b0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: compare items whose cycle has been clocked
    always @(negedge clk) begin
        if (rst_n && bit_cycle_o === 1'b1) seen_pulses++;
        while (q.size() > 0 && q[0].stamp < cyc) begin
            exp_t e;
            e = q.pop_front();
            check1({e.tag, " pulse"}, bit_cycle_o, e.p);
            check1({e.tag, " gate"},  gate_open_o, e.g);
            check1({e.tag, " check"}, check_window_o, e.c);
        end
    end

    task automatic tick(input string tag);
        logic [3:0] e;
        logic sel;
        int   nx;
        exp_t it;
        e   = phase_in & ~m_prev;
        sel = drum_mode ? (e[0] | e[2]) : e[normal_sel];
        nx  = m_st;
        if (idle_rst) nx = 0;
        else case (m_st)
            0: if (area_start) nx = 2; else if (hold_on_index) nx = 1;
            1: if (area_start) nx = 2;
            2: if (!drum_mode && read_mode && d2_bs_strobe) nx = 0;
               else if (check_area) nx = 3;
            3: if (drum_mode ? d5_strobe : late_end_strobe) nx = 0;
            default: nx = 0;
        endcase
        it.stamp = cyc;
        it.p     = !idle_rst && (m_st != 0) && sel;
        it.g     = (nx != 0);
        it.c     = (nx == 3);
        it.tag   = tag;
        q.push_back(it);
        m_st   = nx;
        m_prev = phase_in;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic track_cycle(input string tag);
        for (int p = 0; p < 4; p++) begin
            phase_in = 4'b1 << p;
            tick(tag);
            phase_in = 4'b0;
            tick(tag);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1 reset pulse", bit_cycle_o, 1'b0);
        check1("R1 reset gate", gate_open_o, 1'b0);
        check1("R1 reset check", check_window_o, 1'b0);

        // R6: closed gate, drum phases produce nothing
        drum_mode = 1'b1;
        track_cycle("R6 closed");

        // R7: area start opens the gate
        area_start = 1'b1; tick("R7 open"); area_start = 1'b0;

        // R2 R3 R12: full track cycle gives pulses on phases one and three only
        seen_pulses = 0;
        track_cycle("R2 R3 drum cycle");
        tick("R12 drain");
        check1("R12 two per track cycle", (seen_pulses == 2), 1'b1);

        // R5: held phase one, one pulse
        phase_in = 4'b0001;
        for (int i = 0; i < 5; i++) tick("R5 held");
        phase_in = 4'b0;
        tick("R5 release");

        // R9: drum read ignores the D2 stop
        read_mode = 1'b1;
        d2_bs_strobe = 1'b1; tick("R9 drum d2 ignored"); d2_bs_strobe = 1'b0;
        track_cycle("R9 drum still flowing");

        // R10: drum check window, late ignored, D5 ends
        check_area = 1'b1; tick("R10 enter check"); check_area = 1'b0;
        late_end_strobe = 1'b1; tick("R10 drum late ignored"); late_end_strobe = 1'b0;
        track_cycle("R10 drum check pulses");
        d5_strobe = 1'b1; tick("R10 drum d5 ends"); d5_strobe = 1'b0;

        // R4: normal mode passes only phase two
        drum_mode = 1'b0; normal_sel = 2'd1;
        area_start = 1'b1; tick("R7 normal open"); area_start = 1'b0;
        track_cycle("R4 normal sel1");
        normal_sel = 2'd3;
        track_cycle("R4 normal sel3");

        // R9: normal read stops at D2
        d2_bs_strobe = 1'b1; tick("R9 normal d2 stop"); d2_bs_strobe = 1'b0;
        track_cycle("R6 normal closed");

        // R10: normal check, D5 ignored, late ends
        read_mode = 1'b0;
        area_start = 1'b1; tick("R7 reopen"); area_start = 1'b0;
        d2_bs_strobe = 1'b1; tick("R9 write d2 ignored"); d2_bs_strobe = 1'b0;
        check_area = 1'b1; tick("R10 normal enter"); check_area = 1'b0;
        d5_strobe = 1'b1; tick("R10 normal d5 ignored"); d5_strobe = 1'b0;
        late_end_strobe = 1'b1; tick("R10 normal late ends"); late_end_strobe = 1'b0;

        // R8: index hold opens, then area start moves on
        drum_mode = 1'b1;
        hold_on_index = 1'b1; tick("R8 index open"); hold_on_index = 1'b0;
        track_cycle("R8 index pulses");
        area_start = 1'b1; tick("R7 index to run"); area_start = 1'b0;

        // R11: idle reset with a phase edge and area start in the same cycle
        idle_rst = 1'b1; area_start = 1'b1; phase_in = 4'b0100;
        tick("R11 idle clear");
        idle_rst = 1'b0; area_start = 1'b0; phase_in = 4'b0;
        tick("R11 after clear");
        track_cycle("R11 stays closed");
        tick("drain");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule